// File: doc/BRIEF.md
# Sticky Status Flag Register

This block holds the 16-bit status word of a three-channel converter's serial interface. Event pulses from elsewhere in the design set sticky fault and event flags. Those flags stay set until a status read strobe arrives. The strobe is raised either for a no-op command or for a register read that targets the status address. The read that clears them still presents their old values, because the output is combinational and the clear happens at the clock edge that ends the read cycle.

The flags do not all clear the same way:
- A reset-occurred flag starts at one. Status reads leave it untouched. Only a mode-register write that carries a zero in its reset bit clears it.
- An interface-lock flag follows lock and unlock commands.
- A fuse-parity flag is driven by a fault level. It sets again at once while that level stays high.

The word also carries fields that are live or mirrored and cannot be written:
- the per-channel data-ready bits;
- the CRC-type selection and the word-length selection.

Command decoding, CRC calculation and the analog fault detectors are outside this block.

Top module: `stat_flag_reg`

## Requirements
- R1: After reset, with CRC type 0, word length 01b and no data ready, the status word reads 0x0540. In that word bit 10 (reset flag) is 1, bits 9:8 are 01b and bit 6 (supply fault) is 1; every other bit is 0.
- R2: A one-cycle pulse on the resync, map-CRC, input-CRC or supply event input sets, respectively, bit 14, 13, 12 or 6 from the next cycle on. The bit then holds while no status read occurs.
- R3: A status read strobe clears bits 14, 13, 12, 7 and 6 from the next cycle on. During the strobe cycle the word still shows the values from before the clear.
- R4: When a set event and a status read fall in the same cycle, the flag is 1 afterwards.
- R5: Bit 7 sets whenever the fuse fault level is high. A status read while the level is still high leaves bit 7 at 1, and a read after the level has dropped clears it.
- R6: Bit 10 is set by a reset command pulse. It is cleared only by a mode write whose reset-bit value is 0. A status read, or a mode write with that value 1, leaves it unchanged.
- R7: Bit 15 is set by a lock command and cleared by an unlock command, and status reads leave it unchanged. If lock and unlock arrive in the same cycle, lock wins.
- R8: Bits 2:0 show the live data-ready inputs of channels 2..0 in the same cycle, and bits 5:3 always read 000b.
- R9: Bit 11 shows the CRC type input (0 = CCITT, 1 = ANSI) and bits 9:8 show the word-length input, both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (pin or power-on) |
| ev_resync | input | 1 | Resynchronisation event pulse |
| ev_map_crc | input | 1 | Register-map CRC fault pulse |
| ev_rx_crc | input | 1 | Input CRC error pulse |
| ev_supply | input | 1 | High-side supply or barrier link fault pulse |
| fuse_fault | input | 1 | Fuse parity fault level |
| cmd_reset | input | 1 | Reset command pulse |
| mode_wr | input | 1 | Mode register write strobe |
| mode_rst_bit | input | 1 | Reset-bit value carried by the mode write |
| cmd_lock | input | 1 | Lock command pulse |
| cmd_unlock | input | 1 | Unlock command pulse |
| stat_rd | input | 1 | Status read strobe (no-op or status-address read) |
| drdy | input | 3 | Live data-ready per channel |
| crc_type | input | 1 | CRC type selection from mode register |
| wlen | input | 2 | Word-length selection from mode register |
| stat_o | output | 16 | Status word |

## Verification
The bench aims at the same-cycle collision of a set event and a clearing read. A design in which clear wins there would silently lose the event.

It checks that the word seen during the read strobe is the value before the clear. A design that cleared one cycle early would return zeros to the host.

It holds the fuse fault level across a read. A design that treats the flag as an edge-set bit would then report no fault.

It confirms that reads, and mode writes carrying a one, leave the reset and lock flags alone. A design that routed the read clear to every flag would drop both indications.

// File: rtl/stat_pkg.sv
package stat_pkg;
   localparam int unsigned WORD_W     = 16;
   localparam int unsigned N_STICKY   = 5;
   localparam int unsigned POS_LOCK   = 15;
   localparam int unsigned POS_CRCTYP = 11;
   localparam int unsigned POS_RSTFLG = 10;
   localparam int unsigned POS_WLEN   = 8;
   // sticky index: 0 resync, 1 map crc, 2 rx crc, 3 fuse, 4 supply
   localparam int unsigned STICKY_POS [N_STICKY] = '{14, 13, 12, 7, 6};
   localparam logic [N_STICKY-1:0] STICKY_RST = 5'b10000;
endpackage

// File: rtl/stat_sticky_bit.sv
module stat_sticky_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_VAL;
      else if (set_i)  q <= 1'b1;
      else if (clr_i)  q <= 1'b0;
   end

   assign q_o = q;

   // R4: a set wins over a simultaneous clear
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R3: clearing read without set empties the flag
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   // R2: the flag holds when neither set nor clear
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/stat_rst_flag.sv
module stat_rst_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_reset_i,
   input  logic mode_wr_i,
   input  logic mode_bit_i,
   output logic q_o
);
   logic q;
   logic clr;

   assign clr = mode_wr_i && !mode_bit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= 1'b1;
      else if (cmd_reset_i) q <= 1'b1;
      else if (clr)         q <= 1'b0;
   end

   assign q_o = q;

   // R6: writing zero to the mode reset bit clears the flag
   p_mode_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr_i && !mode_bit_i && !cmd_reset_i) |=> !q_o);
   // R6: nothing but a zero mode write lowers the flag
   p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !(mode_wr_i && !mode_bit_i)) |=> q_o);
   // R6: the reset command raises it
   p_cmd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset_i |=> q_o);
endmodule

// File: rtl/stat_lock_bit.sv
module stat_lock_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_i,
   input  logic unlock_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (lock_i)   q <= 1'b1;
      else if (unlock_i) q <= 1'b0;
   end

   assign q_o = q;

   // R7: lock command (wins over unlock)
   p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> q_o);
   // R7: unlock alone clears
   p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_i && !lock_i) |=> !q_o);
   // R7: otherwise unchanged
   p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_i && !unlock_i) |=> $stable(q_o));
endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg
   import stat_pkg::*;
#(
   parameter int unsigned NCH    = 3,
   parameter int unsigned WLEN_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_resync,
   input  logic              ev_map_crc,
   input  logic              ev_rx_crc,
   input  logic              ev_supply,
   input  logic              fuse_fault,
   input  logic              cmd_reset,
   input  logic              mode_wr,
   input  logic              mode_rst_bit,
   input  logic              cmd_lock,
   input  logic              cmd_unlock,
   input  logic              stat_rd,
   input  logic [NCH-1:0]    drdy,
   input  logic              crc_type,
   input  logic [WLEN_W-1:0] wlen,
   output logic [WORD_W-1:0] stat_o
);
   localparam int unsigned RSV_LO = NCH;
   localparam int unsigned RSV_HI = 5;

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("NCH must be 1..3");
   end
   if (WLEN_W != 2) begin : g_bad_wlen
      $error("WLEN_W must be 2");
   end

   logic [N_STICKY-1:0] sticky_set;
   logic [N_STICKY-1:0] sticky_q;
   logic                lock_q;
   logic                rstflg_q;

   assign sticky_set = {ev_supply, fuse_fault, ev_rx_crc, ev_map_crc, ev_resync};

   for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
      stat_sticky_bit #(.RST_VAL(STICKY_RST[i])) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (sticky_set[i]),
         .clr_i (stat_rd),
         .q_o   (sticky_q[i])
      );
   end

   stat_rst_flag u_rstflg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_reset_i (cmd_reset),
      .mode_wr_i   (mode_wr),
      .mode_bit_i  (mode_rst_bit),
      .q_o         (rstflg_q)
   );

   stat_lock_bit u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_i   (cmd_lock),
      .unlock_i (cmd_unlock),
      .q_o      (lock_q)
   );

   always_comb begin
      stat_o = '0;
      stat_o[POS_LOCK]   = lock_q;
      stat_o[POS_CRCTYP] = crc_type;
      stat_o[POS_RSTFLG] = rstflg_q;
      stat_o[POS_WLEN +: WLEN_W] = wlen;
      for (int i = 0; i < N_STICKY; i++) stat_o[STICKY_POS[i]] = sticky_q[i];
      stat_o[NCH-1:0] = drdy;
   end

   // R5: fuse level still present across a read keeps bit 7 set
   p_fuse_reassert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_fault && stat_rd) |=> stat_o[7]);
   // R8: reserved field stays zero
   p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[RSV_HI:RSV_LO] == '0);
endmodule

// File: tb/sim_stat_flag_reg.sv
module sim_stat_flag_reg;
   logic clk = 0;
   logic rst_n = 0;
   logic ev_resync = 0, ev_map_crc = 0, ev_rx_crc = 0, ev_supply = 0;
   logic fuse_fault = 0, cmd_reset = 0, mode_wr = 0, mode_rst_bit = 0;
   logic cmd_lock = 0, cmd_unlock = 0, stat_rd = 0, crc_type = 0;
   logic [2:0] drdy = 0;
   logic [1:0] wlen = 2'b01;
   logic [15:0] stat_o;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   stat_flag_reg u0 (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic nxt(); @(negedge clk); endtask

   task automatic do_read(); stat_rd = 1; nxt(); stat_rd = 0; endtask

   task automatic t_reset();
      chk("R1 reset word", stat_o, 16'h0540);
   endtask

   task automatic t_sticky();
      do_read();
      chk("R3 supply cleared", stat_o, 16'h0500);
      ev_resync = 1; nxt(); ev_resync = 0;
      chk("R2 resync bit14", stat_o, 16'h4500);
      ev_map_crc = 1; nxt(); ev_map_crc = 0;
      ev_rx_crc = 1; nxt(); ev_rx_crc = 0;
      ev_supply = 1; nxt(); ev_supply = 0;
      repeat (3) nxt();
      chk("R2 sticky hold", stat_o, 16'h7540);
   endtask

   task automatic t_read_clear();
      stat_rd = 1; #1;
      chk("R3 pre-clear value during read", stat_o, 16'h7540);
      nxt(); stat_rd = 0;
      chk("R3 cleared after read", stat_o, 16'h0500);
   endtask

   task automatic t_set_vs_read();
      ev_map_crc = 1; ev_rx_crc = 1; stat_rd = 1; nxt();
      ev_map_crc = 0; ev_rx_crc = 0; stat_rd = 0;
      chk("R4 set wins over read", stat_o, 16'h3500);
      do_read();
      chk("R4 later read clears", stat_o, 16'h0500);
   endtask

   task automatic t_fuse();
      fuse_fault = 1; nxt();
      chk("R5 fuse sets", stat_o, 16'h0580);
      do_read();
      chk("R5 fuse reasserts under read", stat_o, 16'h0580);
      fuse_fault = 0; nxt();
      chk("R5 fuse sticky after level drops", stat_o, 16'h0580);
      do_read();
      chk("R5 fuse clears", stat_o, 16'h0500);
   endtask

   task automatic t_rst_flag();
      do_read();
      chk("R6 read keeps reset flag", stat_o, 16'h0500);
      mode_wr = 1; mode_rst_bit = 1; nxt(); mode_wr = 0;
      chk("R6 write 1 keeps", stat_o, 16'h0500);
      mode_rst_bit = 0; mode_wr = 1; nxt(); mode_wr = 0;
      chk("R6 write 0 clears", stat_o, 16'h0100);
      cmd_reset = 1; nxt(); cmd_reset = 0;
      chk("R6 command sets", stat_o, 16'h0500);
      mode_wr = 1; nxt(); mode_wr = 0;
      chk("R6 cleared again", stat_o, 16'h0100);
   endtask

   task automatic t_lock();
      cmd_lock = 1; nxt(); cmd_lock = 0;
      chk("R7 locked", stat_o, 16'h8100);
      do_read();
      chk("R7 read keeps lock", stat_o, 16'h8100);
      cmd_unlock = 1; nxt(); cmd_unlock = 0;
      chk("R7 unlocked", stat_o, 16'h0100);
      cmd_lock = 1; cmd_unlock = 1; nxt(); cmd_lock = 0; cmd_unlock = 0;
      chk("R7 lock wins", stat_o, 16'h8100);
      cmd_unlock = 1; nxt(); cmd_unlock = 0;
   endtask

   task automatic t_live();
      drdy = 3'b101; #1;
      chk("R8 drdy live", stat_o, 16'h0105);
      drdy = 3'b010; #1;
      chk("R8 drdy live second", stat_o, 16'h0102);
      drdy = 3'b111; crc_type = 1; wlen = 2'b11; #1;
      chk("R9 mirror crc and wlen", stat_o, 16'h0B07);
      wlen = 2'b10; crc_type = 0; drdy = 0; #1;
      chk("R9 wlen 10", stat_o, 16'h0200);
      nxt();
   endtask

   initial begin
      repeat (3) nxt();
      rst_n = 1;
      nxt();
      t_reset();
      t_sticky();
      t_read_clear();
      t_set_vs_read();
      t_fuse();
      t_rst_flag();
      t_lock();
      t_live();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule